// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where the execute stage of a five-stage pipeline takes its two ALU operands from, and where the memory stage takes a store's write data from. It compares the two source register numbers of the instruction now entering execute with the destination register numbers held in the two pipeline registers ahead of it: execute/memory and memory/writeback. A destination only counts as a forwarding source when its write-enable flag is set and the register number is not zero.

The unit has a second, separate path for stores. A store sitting in the memory stage can take its data from the memory/writeback register when the instruction just ahead of it is a load that writes the store's data register. Because of this path, a store placed directly after a load needs no stall. The stall decision itself, the register file and the multiplexers that the selects drive all sit outside this block.

The selects are registered once on the clock, with a synchronous active-high reset. Each select therefore reflects the pipeline fields that were present at the previous rising edge.

Top module: `fwd_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every select is cleared on that edge: `sel_a` = 00, `sel_b` = 00 and `sel_sd` = 0, whatever the other inputs are.
- R2: The operand select code is 00 for the register file, 10 for the execute/memory register and 01 for the memory/writeback register. Code 11 never appears.
- R3: When `exm_wen` = 1, `exm_dst` is non-zero and `exm_dst` equals a source register, that operand's select is 10.
- R4: When the execute/memory register does not supply an operand, and `mwb_wen` = 1, `mwb_dst` is non-zero and `mwb_dst` equals the source, that operand's select is 01. This covers a loaded value reaching a consumer after one bubble, or two instructions later with no bubble.
- R5: When both stages match the same source, the execute/memory value wins and the select is 10. Of two back-to-back writes to one register, the younger one reaches later consumers.
- R6: A destination of register 0 is never forwarded, even when its write-enable is set.
- R7: A stage whose write-enable is 0, such as a bubble, is never a forwarding source, even when its register field matches.
- R8: `sel_sd` = 1 only when all of these hold: `exm_store` = 1, `mwb_load` = 1, `mwb_wen` = 1, `mwb_dst` is non-zero and `mwb_dst` equals `exm_sdreg`. Otherwise it is 0.
- R9: Operand A follows `id_rs` and operand B follows `id_rt`, each independently of the other. Every select shows the result for the inputs present at the previous rising edge, which is a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | REG_W | First source register of the instruction entering execute |
| id_rt | input | REG_W | Second source register of the instruction entering execute |
| exm_dst | input | REG_W | Destination register held in the execute/memory register |
| exm_wen | input | 1 | Register write flag of the execute/memory register |
| mwb_dst | input | REG_W | Destination register held in the memory/writeback register |
| mwb_wen | input | 1 | Register write flag of the memory/writeback register |
| mwb_load | input | 1 | The memory/writeback instruction is a load |
| exm_store | input | 1 | The execute/memory instruction is a store |
| exm_sdreg | input | REG_W | Data register of the store in the memory stage |
| sel_a | output | 2 | Select for operand A |
| sel_b | output | 2 | Select for operand B |
| sel_sd | output | 1 | Store data select: 1 takes the memory/writeback value |

## Verification
Every select is due exactly one rising edge after the register fields that produce it are applied. The bench applies a new set of fields on each falling edge, waits for the next rising edge and then a quarter period, and compares all three outputs against values it has computed from the fields it just applied. The checker module delays its antecedents by one cycle with `$past` for the same reason, and only starts to check once a full cycle has passed out of reset.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source selects; the bit positions are decoded by the execute muxes.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A producer qualifies only when it writes, targets a real register
  // and that register is the one the consumer reads.
  always_comb begin
    hit = wen && (dst != ZERO_REG) && (dst == src);
  end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     hit_exm,
  input  logic     hit_mwb,
  output fwd_sel_e sel
);

  // The younger producer (execute/memory) shadows the older one.
  always_comb begin
    if (hit_exm)      sel = FWD_EXM;
    else if (hit_mwb) sel = FWD_MWB;
    else              sel = FWD_RF;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic             mwb_wen,
  input  logic             mwb_load,
  input  logic             exm_store,
  input  logic [REG_W-1:0] exm_sdreg,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             sel_sd
);

  logic [REG_W-1:0] op_src [NUM_OPS];
  fwd_sel_e         op_sel [NUM_OPS];
  fwd_sel_e         op_q   [NUM_OPS];

  assign op_src[0] = id_rs;
  assign op_src[1] = id_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic hit_exm;
    logic hit_mwb;

    fwd_hit #(.REG_W(REG_W)) u_exm (
      .src (op_src[g]),
      .dst (exm_dst),
      .wen (exm_wen),
      .hit (hit_exm)
    );

    fwd_hit #(.REG_W(REG_W)) u_mwb (
      .src (op_src[g]),
      .dst (mwb_dst),
      .wen (mwb_wen),
      .hit (hit_mwb)
    );

    fwd_pick u_pick (
      .hit_exm (hit_exm),
      .hit_mwb (hit_mwb),
      .sel     (op_sel[g])
    );

    always_ff @(posedge clk) begin
      if (rst) op_q[g] <= FWD_RF;
      else     op_q[g] <= op_sel[g];
    end
  end

  // Store data path: a load just ahead feeds the store in the memory stage.
  logic sd_qual;
  logic sd_hit;
  logic sd_q;

  assign sd_qual = mwb_wen && mwb_load && exm_store;

  fwd_hit #(.REG_W(REG_W)) u_sd (
    .src (exm_sdreg),
    .dst (mwb_dst),
    .wen (sd_qual),
    .hit (sd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) sd_q <= 1'b0;
    else     sd_q <= sd_hit;
  end

  assign sel_a  = op_q[0];
  assign sel_b  = op_q[1];
  assign sel_sd = sd_q;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic [REG_W-1:0] exm_dst,
  input logic             exm_wen,
  input logic [REG_W-1:0] mwb_dst,
  input logic             mwb_wen,
  input logic             mwb_load,
  input logic             exm_store,
  input logic [REG_W-1:0] exm_sdreg,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             sel_sd
);

  // armed is high once the previous edge was outside reset.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  assert_no_code11_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (sel_a != 2'b11 && sel_b != 2'b11));

  assert_exm_wins_a_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(exm_wen && exm_dst != '0 && exm_dst == id_rs)) |-> sel_a == 2'b10);

  assert_exm_wins_b_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(exm_wen && exm_dst != '0 && exm_dst == id_rt)) |-> sel_b == 2'b10);

  assert_mwb_a_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!(exm_wen && exm_dst == id_rs) && mwb_wen && mwb_dst != '0
                    && mwb_dst == id_rs)) |-> sel_a == 2'b01);

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(exm_dst == '0 && mwb_dst == '0)) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !sel_sd));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!exm_wen && !mwb_wen)) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !sel_sd));

  assert_store_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (sel_sd == $past(exm_store && mwb_load && mwb_wen && mwb_dst != '0
                               && mwb_dst == exm_sdreg)));

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .id_rs     (id_rs),
  .id_rt     (id_rt),
  .exm_dst   (exm_dst),
  .exm_wen   (exm_wen),
  .mwb_dst   (mwb_dst),
  .mwb_wen   (mwb_wen),
  .mwb_load  (mwb_load),
  .exm_store (exm_store),
  .exm_sdreg (exm_sdreg),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .sel_sd    (sel_sd)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;

  localparam int unsigned REG_W  = 5;
  localparam int unsigned CLK_NS = 10;
  localparam int unsigned N_RAND = 3000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [REG_W-1:0] id_rs = '0, id_rt = '0, exm_dst = '0, mwb_dst = '0, exm_sdreg = '0;
  logic             exm_wen = 1'b0, mwb_wen = 1'b0, mwb_load = 1'b0, exm_store = 1'b0;
  logic [1:0]       sel_a, sel_b;
  logic             sel_sd;

  int n_cmp  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  fwd_unit #(.REG_W(REG_W)) u0 (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt),
    .exm_dst(exm_dst), .exm_wen(exm_wen), .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
    .mwb_load(mwb_load), .exm_store(exm_store), .exm_sdreg(exm_sdreg),
    .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd)
  );

  // Reference: scan producers from youngest to oldest, return the first usable one.
  function automatic int ref_op(input int src, input int e_d, input bit e_w,
                                input int m_d, input bit m_w);
    int younger [2] = '{e_d, m_d};
    bit writes  [2] = '{e_w, m_w};
    int code    [2] = '{2, 1};
    for (int k = 0; k < 2; k++)
      if (writes[k] && younger[k] != 0 && younger[k] == src) return code[k];
    return 0;
  endfunction

  function automatic int ref_sd(input bit st, input bit ld, input bit m_w,
                                input int m_d, input int sdr);
    return (st && ld && m_w && m_d != 0 && m_d == sdr) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Apply one set of fields at a falling edge and compare one clock later.
  task automatic step(input string tag, input int rs, input int rt,
                      input int ed, input bit ew, input int md, input bit mw,
                      input bit ld, input bit st, input int sdr);
    int ea, eb, es;
    @(negedge clk);
    id_rs = REG_W'(rs); id_rt = REG_W'(rt);
    exm_dst = REG_W'(ed); exm_wen = ew;
    mwb_dst = REG_W'(md); mwb_wen = mw; mwb_load = ld;
    exm_store = st; exm_sdreg = REG_W'(sdr);
    ea = ref_op(rs, ed, ew, md, mw);
    eb = ref_op(rt, ed, ew, md, mw);
    es = ref_sd(st, ld, mw, md, sdr);
    @(posedge clk);
    #(CLK_NS/4);
    check(tag, "sel_a", int'(sel_a), ea);
    check(tag, "sel_b", int'(sel_b), eb);
    check(tag, "sel_sd", int'(sel_sd), es);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    // R1: reset with every field set up to forward
    @(negedge clk);
    rst = 1'b1;
    id_rs = 5'd3; id_rt = 5'd3; exm_dst = 5'd3; exm_wen = 1'b1;
    mwb_dst = 5'd4; mwb_wen = 1'b1; mwb_load = 1'b1; exm_store = 1'b1; exm_sdreg = 5'd4;
    @(posedge clk); #(CLK_NS/4);
    check("R1", "sel_a", int'(sel_a), 0);
    check("R1", "sel_b", int'(sel_b), 0);
    check("R1", "sel_sd", int'(sel_sd), 0);
    @(negedge clk);
    rst = 1'b0;

    step("R3", 2, 7, 2, 1, 9, 0, 0, 0, 0);   // A from execute/memory
    step("R3", 7, 2, 2, 1, 9, 0, 0, 0, 0);   // B from execute/memory
    step("R4", 6, 1, 9, 1, 6, 1, 1, 0, 0);   // load after one bubble, A from memory/writeback
    step("R9", 6, 5, 5, 1, 6, 1, 0, 0, 0);   // A and B from different stages
    step("R5", 8, 8, 8, 1, 8, 1, 1, 0, 0);   // two loads to one register: younger wins
    step("R6", 0, 0, 0, 1, 0, 1, 1, 1, 0);   // register 0 never forwarded
    step("R7", 4, 4, 4, 0, 4, 0, 1, 1, 4);   // bubbles never forward
    step("R7", 4, 3, 4, 0, 4, 1, 0, 0, 0);   // bubble in execute/memory, memory/writeback used
    step("R8", 1, 1, 2, 0, 11, 1, 1, 1, 11); // store data from the load just ahead
    step("R8", 1, 1, 2, 0, 11, 1, 0, 1, 11); // ALU result ahead: no store forward
    step("R8", 1, 1, 2, 0, 11, 1, 1, 0, 11); // not a store: no store forward
    step("R2", 31, 31, 31, 1, 31, 1, 1, 1, 31);

    // R9 and R2 to R8 together: random fields drawn from a narrow register range
    for (int i = 0; i < N_RAND; i++) begin
      int lim;
      lim = (i % 4 == 0) ? 31 : 3;
      step("R9", $urandom_range(0, lim), $urandom_range(0, lim),
           $urandom_range(0, lim), 1'($urandom_range(0, 1)),
           $urandom_range(0, lim), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, lim));
    end

    // R1 again: reset in the middle of traffic clears all selects
    @(negedge clk);
    rst = 1'b1;
    id_rs = 5'd5; exm_dst = 5'd5; exm_wen = 1'b1;
    @(posedge clk); #(CLK_NS/4);
    check("R1", "sel_a", int'(sel_a), 0);
    check("R1", "sel_sd", int'(sel_sd), 0);
    finish_run();
  end

  initial begin
    #(CLK_NS * 100000);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule